// File: doc/BRIEF.md
# Background Error Counter Snapshot

This block keeps one hidden running count for each of several line error event strobes, such as framing-bit, M-bit or parity error indications from a framer. Software never reads these running counts directly. It reads a foreground register per event type. Those registers change only when a transfer happens. A transfer loads every foreground register from its running count, and in the same cycle it zeroes the running counts. Each measurement interval therefore starts cleanly, and no event is counted twice.

A mode input picks what causes a transfer. When the mode is low, which is the register's reset value, only a software copy command causes a transfer. When the mode is high, a transfer happens automatically on every one-second tick. In that mode the block raises an interrupt pulse in the same cycle that the foreground registers take the new values, so software knows it should read them. The framer, the register decoding and the one-second timebase are outside this block, and their signals arrive here as inputs.

Top module: `err_snap_top`

## Requirements
- R1: After reset, every foreground count is 0 and `readIrq` is 0.
- R2: Every cycle in which bit i of `errStrb` is high adds 1 to the running count of channel i. A foreground count does not change until a transfer happens.
- R3: When `autoMode` is 0, a cycle with `copyCmd` high is a transfer. After the next rising clock edge, each foreground count equals the number of events that channel had since the previous transfer or reset.
- R4: When `autoMode` is 1, a cycle with `secTick` high is a transfer, and the timing is the same as in R3.
- R5: A transfer zeroes the running counts. A second transfer with no events in between gives foreground counts of 0.
- R6: An event that arrives in the same cycle as a transfer is not part of the transferred value. It counts as 1 in the new interval.
- R7: A running count stops at 2^CNT_W-1 and does not wrap. The foreground register then reports that maximum value.
- R8: Between transfers, the foreground counts stay unchanged whatever events arrive.
- R9: When `autoMode` is 1, `copyCmd` has no effect. When `autoMode` is 0, `secTick` has no effect.
- R10: `readIrq` is high for exactly one cycle, at the same time as the foreground update of a periodic transfer (mode 1). It stays low for transfers caused by a copy command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| errStrb | input | NUM_CNT | One error event strobe per channel |
| secTick | input | 1 | One-cycle pulse marking each second |
| copyCmd | input | 1 | One-cycle software copy command |
| autoMode | input | 1 | 0: transfer on copy command, 1: transfer on one-second tick |
| fgCount | output | NUM_CNT*CNT_W | Foreground counts, channel i in bits [i*CNT_W +: CNT_W] |
| readIrq | output | 1 | Read-interrupt pulse issued with each periodic transfer |

## Verification
The assertions assume that `secTick` and `copyCmd` are single-cycle pulses and that `autoMode` changes only between transfers. They treat the trigger selected by the mode as the only source of a transfer. The bench changes every input on the falling edge of the clock. It never changes `autoMode` in the same cycle as a pulse. This keeps every transfer tied to exactly one clock edge that can be identified. The cases where an event and a transfer land in the same cycle are produced on purpose, by raising both strobes together.

// File: rtl/err_snap_pkg.sv
package err_snap_pkg;
  typedef struct packed {
    logic doXfer;
    logic periodic;
  } snapCtl_t;
endpackage

// File: rtl/err_snap_ctrl.sv
module err_snap_ctrl
  import err_snap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     secTick,
  input  logic     copyCmd,
  input  logic     autoMode,
  output snapCtl_t ctl,
  output logic     readIrq
);
  always_comb begin
    ctl.periodic = autoMode && secTick;
    ctl.doXfer   = autoMode ? secTick : copyCmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) readIrq <= 1'b0;
    else        readIrq <= ctl.periodic;
  end
endmodule

// File: rtl/err_snap_dp.sv
module err_snap_dp
  import err_snap_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       errStrb,
  input  snapCtl_t                 ctl,
  output logic [NUM_CNT*CNT_W-1:0] fgCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chan
    logic [CNT_W-1:0] bgCnt;
    logic [CNT_W-1:0] fgCnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bgCnt <= '0;
        fgCnt <= '0;
      end else if (ctl.doXfer) begin
        fgCnt <= bgCnt;
        bgCnt <= errStrb[i] ? CNT_ONE : '0;
      end else if (errStrb[i] && (bgCnt != CNT_MAX)) begin
        bgCnt <= bgCnt + CNT_ONE;
      end
    end

    assign fgCount[i*CNT_W +: CNT_W] = fgCnt;
  end
endmodule

// File: rtl/err_snap_top.sv
module err_snap_top
  import err_snap_pkg::*;
#(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       errStrb,
  input  logic                     secTick,
  input  logic                     copyCmd,
  input  logic                     autoMode,
  output logic [NUM_CNT*CNT_W-1:0] fgCount,
  output logic                     readIrq
);
  snapCtl_t ctl;

  err_snap_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .copyCmd(copyCmd),
    .autoMode(autoMode), .ctl(ctl), .readIrq(readIrq)
  );

  err_snap_dp #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .errStrb(errStrb), .ctl(ctl), .fgCount(fgCount)
  );
endmodule

// File: rtl/err_snap_chk.sv
module err_snap_chk #(
  parameter int NUM_CNT = 3,
  parameter int CNT_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     secTick,
  input logic                     copyCmd,
  input logic                     autoMode,
  input logic [NUM_CNT*CNT_W-1:0] fgCount,
  input logic                     readIrq
);
  AST_HOLD_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    !(autoMode ? secTick : copyCmd) |=> $stable(fgCount)); // R8

  AST_CMD_IGNORED_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (autoMode && copyCmd && !secTick) |=> (!readIrq && $stable(fgCount))); // R9

  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (autoMode && secTick) |=> readIrq); // R10

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    readIrq |-> $past(autoMode && secTick)); // R10

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (readIrq && !(autoMode && secTick)) |=> !readIrq); // R10
endmodule

bind err_snap_top err_snap_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .secTick(secTick), .copyCmd(copyCmd),
  .autoMode(autoMode), .fgCount(fgCount), .readIrq(readIrq)
);

// File: tb/err_snap_tb.sv
module err_snap_top_tb_top;
  localparam int NUM_CNT = 3;
  localparam int CNT_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CNT-1:0] errStrb = '0;
  logic secTick = 1'b0, copyCmd = 1'b0, autoMode = 1'b0;
  logic [NUM_CNT*CNT_W-1:0] fgCount;
  logic readIrq;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_snap_top #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .errStrb(errStrb), .secTick(secTick),
    .copyCmd(copyCmd), .autoMode(autoMode), .fgCount(fgCount), .readIrq(readIrq)
  );

  function automatic int fg(int ch);
    return int'(fgCount[ch*CNT_W +: CNT_W]);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkFg(string req, int e0, int e1, int e2);
    check(req, "fg0", fg(0), e0);
    check(req, "fg1", fg(1), e1);
    check(req, "fg2", fg(2), e2);
  endtask

  task automatic addEvents(logic [NUM_CNT-1:0] mask, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) errStrb = mask;
    end
    @(negedge clk) errStrb = '0;
  endtask

  // one-cycle pulse; after return, the edge that sampled it has passed
  task automatic pulseCopy(logic [NUM_CNT-1:0] mask = '0);
    @(negedge clk) begin copyCmd = 1'b1; errStrb = mask; end
    @(negedge clk) begin copyCmd = 1'b0; errStrb = '0; end
  endtask

  task automatic pulseTick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  task automatic testReset();
    checkFg("R1", 0, 0, 0);
    check("R1", "readIrq", int'(readIrq), 0);
  endtask

  task automatic testCmdCopy();
    addEvents(3'b011, 3);
    addEvents(3'b001, 2);
    checkFg("R2", 0, 0, 0);
    pulseCopy();
    checkFg("R3", 5, 3, 0);
    check("R10", "irq on command copy", int'(readIrq), 0);
  endtask

  task automatic testClear();
    pulseCopy();
    checkFg("R5", 0, 0, 0);
  endtask

  task automatic testCoincident();
    addEvents(3'b100, 2);
    pulseCopy(3'b100);
    checkFg("R6", 0, 0, 2);
    pulseCopy();
    checkFg("R6", 0, 0, 1);
  endtask

  task automatic testHold();
    addEvents(3'b111, 4);
    checkFg("R8", 0, 0, 1);
    pulseCopy();
    checkFg("R8", 4, 4, 4);
  endtask

  task automatic testSaturate();
    addEvents(3'b001, 300);
    addEvents(3'b010, 255);
    pulseCopy();
    checkFg("R7", 255, 255, 0);
  endtask

  task automatic testTickIgnoredCmdMode();
    addEvents(3'b010, 2);
    pulseTick();
    checkFg("R9", 255, 255, 0);
    check("R9", "irq in command mode", int'(readIrq), 0);
    pulseCopy();
    checkFg("R9", 0, 2, 0);
  endtask

  task automatic testAutoMode();
    @(negedge clk) autoMode = 1'b1;
    addEvents(3'b100, 6);
    pulseCopy();
    checkFg("R9", 0, 2, 0);
    check("R9", "irq after ignored copy", int'(readIrq), 0);
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
    checkFg("R4", 0, 0, 6);
    check("R10", "irq with periodic copy", int'(readIrq), 1);
    @(negedge clk);
    check("R10", "irq single cycle", int'(readIrq), 0);
    pulseTick();
    checkFg("R5", 0, 0, 0);
    @(negedge clk) autoMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testCmdCopy();
    testClear();
    testCoincident();
    testHold();
    testSaturate();
    testTickIgnoredCmdMode();
    testAutoMode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule